// File: doc/BRIEF.md
# Three-Stage Interpolator With Sample-and-Hold

This block raises a stereo PCM stream by a factor of 64. Each accepted pair of 20-bit left and right samples passes through three cascaded 2x FIR interpolators. Together they produce eight values per channel, one sample period's worth at eight times the input rate. A zero-order hold then presents each of those eight values for eight consecutive output slots. The result is 64 output slots per input sample, which is the rate a downstream noise-shaping modulator consumes. Every output word is 23 bits, signed.

All filter arithmetic runs on one multiply-accumulate unit. A sequencer shares it across the three stages and both channels: the left channel's seven filter steps run first, then the right channel's seven. Each step takes three clocks (shift the delay line, first coefficient pair, second coefficient pair with round, saturate and write-back). The system clock runs CPO times faster than the output slot rate. With the default CPO of 4, one input period is 256 clocks, and the arithmetic uses 42 of them.

Each stage uses the same four-tap symmetric half-band response. A new input x0, with older inputs x1, x2 and x3 in the delay line, makes the stage emit two values in order: first the centre sample x2 unchanged, then the midpoint (9·(x1+x2) − (x0+x3) + 8) >> 4, using an arithmetic floor shift. The midpoint is clamped to the 23-bit signed range.

Top module: `ipc_chain`

## Requirements
- R1: From reset until the first frame is loaded, out_valid is 0 and out_left and out_right are both 0.
- R2: in_valid is accepted on a rising edge only when the block is idle. The first output slot of the resulting frame (out_valid = 1, first value) is visible right after the 43rd rising edge that follows the accepting edge.
- R3: Each stage has delay taps x0 (newest) to x3. For each input it emits x2, then sat((9·(x1+x2) − (x0+x3) + 8) >>> 4), in that order.
- R4: Stage 1 is fed the 20-bit sample multiplied by 8, so the sample is left-aligned in 23 bits. Stage 2 takes stage 1's two outputs in order, and stage 3 takes stage 2's four. The eight stage-3 outputs make up the frame, in emission order.
- R5: Frame value k (k = 0..7) is presented for output slots 8k to 8k+7. A slot lasts CPO = 4 clocks. out_valid is 1 on the first clock of each slot only, and the outputs change only on clocks where out_valid is 1.
- R6: After slot 63, the last frame value stays on the outputs and out_valid keeps pulsing once every 4 clocks until the next frame loads.
- R7: in_valid asserted while a sample is being processed is ignored. It changes neither the outputs nor the filter history.
- R8: Any midpoint above 4194303 is output as 4194303, and any below −4194304 as −4194304. Values never wrap.
- R9: The left and right channels are processed independently, with no effect of one on the other.
- R10: An asynchronous low on rst_n, even in the middle of a frame, returns the block to its R1 state and clears all filter history to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CPO times the output slot rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: a new sample pair is present |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_valid | output | 1 | High on the first clock of each output slot |
| out_left | output | 23 | Left output word, two's complement |
| out_right | output | 23 | Right output word, two's complement |

## Verification
A corrupted delay tap, a swapped coefficient pair or a misrouted buffer write does not stay hidden. The wrong value appears in the very next frame, at the slot group of the stage-3 output it feeds, only 43 clocks after the sample that exposes it. A missing clamp shows up as a sign flip in a saturated frame. A history leak between channels, or across a reset, shows up in the first frame whose expected values depend on the data that was wrongly kept or lost. Timing faults in the hold stage show up within one 4-clock slot, as a pulse or a value change on the wrong clock.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int NCH          = 2;
  localparam int NSTG         = 3;
  localparam int NTAP         = 4;
  localparam int STEPS_PER_CH = 7;   // 1 + 2 + 4 midpoint computations
  localparam int NOUT         = 8;   // values per channel per input
  localparam int REP          = 8;   // hold repetitions per value
  localparam int COEF_W       = 8;
  localparam int FRAC         = 4;

  typedef enum logic [1:0] {
    PH_SHIFT = 2'd0,
    PH_MAC0  = 2'd1,
    PH_MAC1  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_LOAD = 2'd2
  } seq_t;

  // Coefficient ROM: tap 0 weights the inner pair, tap 1 the outer pair.
  function automatic logic signed [COEF_W-1:0] coef_rom(input logic [1:0] stage,
                                                         input logic tap);
    logic signed [COEF_W-1:0] c;
    case (stage)
      2'd0, 2'd1, 2'd2: c = tap ? -8'sd1 : 8'sd9;
      default:          c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ipc_tapline.sv
module ipc_tapline
  import ipc_pkg::*;
#(
  parameter int W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift,
  input  logic [W-1:0]              din,
  output logic [NTAP-1:0][W-1:0]    taps
);

  logic [NTAP-1:0][W-1:0] taps_d;

  always_comb begin
    taps_d = taps;
    if (shift) taps_d = {taps[NTAP-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_d;
  end

endmodule

// File: rtl/ipc_alu.sv
module ipc_alu
  import ipc_pkg::*;
#(
  parameter int W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic signed [W-1:0]      opa,
  input  logic signed [W-1:0]      opb,
  input  logic signed [COEF_W-1:0] coef,
  output logic        [W-1:0]      res
);

  localparam int AW = W + COEF_W + 3;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = {{(AW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [AW-1:0] MINV = {{(AW-W+1){1'b1}}, {(W-1){1'b0}}};

  logic signed [W:0]    pair;
  logic signed [AW-1:0] prod;
  logic signed [AW-1:0] acc, acc_d;
  logic signed [AW-1:0] total;
  logic signed [AW-1:0] scaled;

  always_comb begin
    pair   = {opa[W-1], opa} + {opb[W-1], opb};
    prod   = $signed({{(AW-COEF_W){coef[COEF_W-1]}}, coef})
           * $signed({{(AW-W-1){pair[W]}}, pair});
    acc_d  = acc_en ? prod : acc;
    total  = acc + prod + HALF;
    scaled = total >>> FRAC;
    if (scaled > MAXV)      res = MAXV[W-1:0];
    else if (scaled < MINV) res = MINV[W-1:0];
    else                    res = scaled[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end

endmodule

// File: rtl/ipc_seq.sv
module ipc_seq
  import ipc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       accept,
  output logic       busy,
  output logic       run,
  output phase_t     ph,
  output logic       ch,
  output logic [1:0] stg,
  output logic [1:0] idx,
  output logic       load
);

  localparam int NSTEP = NCH * STEPS_PER_CH;
  localparam int SW    = $clog2(NSTEP);

  seq_t          state, state_d;
  logic [SW-1:0] step, step_d;
  phase_t        ph_d;
  logic [SW-1:0] lstep;

  assign accept = in_valid && (state == SQ_IDLE);
  assign busy   = (state != SQ_IDLE);
  assign run    = (state == SQ_RUN);
  assign load   = (state == SQ_LOAD);

  always_comb begin
    ch    = (step >= SW'(STEPS_PER_CH));
    lstep = ch ? step - SW'(STEPS_PER_CH) : step;
    if (lstep == '0) begin
      stg = 2'd0;
      idx = 2'd0;
    end else if (lstep <= SW'(2)) begin
      stg = 2'd1;
      idx = 2'(lstep - SW'(1));
    end else begin
      stg = 2'd2;
      idx = 2'(lstep - SW'(3));
    end
  end

  always_comb begin
    state_d = state;
    step_d  = step;
    ph_d    = ph;
    case (state)
      SQ_IDLE: begin
        if (in_valid) begin
          state_d = SQ_RUN;
          step_d  = '0;
          ph_d    = PH_SHIFT;
        end
      end
      SQ_RUN: begin
        case (ph)
          PH_SHIFT: ph_d = PH_MAC0;
          PH_MAC0:  ph_d = PH_MAC1;
          default: begin
            ph_d = PH_SHIFT;
            if (step == SW'(NSTEP - 1)) state_d = SQ_LOAD;
            else                        step_d  = step + SW'(1);
          end
        endcase
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      step  <= '0;
      ph    <= PH_SHIFT;
    end else begin
      state <= state_d;
      step  <= step_d;
      ph    <= ph_d;
    end
  end

endmodule

// File: rtl/ipc_hold.sv
module ipc_hold
  import ipc_pkg::*;
#(
  parameter int W   = 23,
  parameter int CPO = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NOUT-1:0][W-1:0] frm_l,
  input  logic [NOUT-1:0][W-1:0] frm_r,
  output logic                  out_valid,
  output logic [W-1:0]          out_l,
  output logic [W-1:0]          out_r
);

  localparam int NSLOT = NOUT * REP;
  localparam int SLW   = $clog2(NSLOT);
  localparam int DW    = (CPO > 1) ? $clog2(CPO) : 1;
  localparam int RSH   = $clog2(REP);

  logic [NOUT-1:0][W-1:0] hl, hr, hl_d, hr_d;
  logic                   act, act_d;
  logic [DW-1:0]          div, div_d;
  logic [SLW-1:0]         slot, slot_d;
  logic [SLW-RSH-1:0]     vsel;

  assign vsel      = slot[SLW-1:RSH];
  assign out_valid = act && (div == '0);
  assign out_l     = hl[vsel];
  assign out_r     = hr[vsel];

  always_comb begin
    hl_d   = hl;
    hr_d   = hr;
    act_d  = act;
    div_d  = div;
    slot_d = slot;
    if (load) begin
      hl_d   = frm_l;
      hr_d   = frm_r;
      act_d  = 1'b1;
      div_d  = '0;
      slot_d = '0;
    end else if (act) begin
      if (div == DW'(CPO - 1)) begin
        div_d = '0;
        if (slot != SLW'(NSLOT - 1)) slot_d = slot + SLW'(1);
      end else begin
        div_d = div + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl   <= '0;
      hr   <= '0;
      act  <= 1'b0;
      div  <= '0;
      slot <= '0;
    end else begin
      hl   <= hl_d;
      hr   <= hr_d;
      act  <= act_d;
      div  <= div_d;
      slot <= slot_d;
    end
  end

endmodule

// File: rtl/ipc_chain.sv
module ipc_chain
  import ipc_pkg::*;
#(
  parameter int IN_W  = 20,
  parameter int OUT_W = 23,
  parameter int CPO   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_left,
  input  logic [IN_W-1:0]  in_right,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_left,
  output logic [OUT_W-1:0] out_right
);

  localparam int SH  = OUT_W - IN_W;
  localparam int LAT = 3 * NCH * STEPS_PER_CH + 1;

  // reset: asserts at once, leaves on the second clock
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic       accept, busy, run, load, ch;
  phase_t     ph;
  logic [1:0] stg, idx;

  ipc_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid),
    .accept(accept), .busy(busy), .run(run), .ph(ph),
    .ch(ch), .stg(stg), .idx(idx), .load(load)
  );

  // captured sample pair
  logic [NCH-1:0][IN_W-1:0] smp, smp_d;
  always_comb begin
    smp_d = smp;
    if (accept) smp_d = {in_right, in_left};
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) smp <= '0;
    else             smp <= smp_d;
  end

  // per-stage result buffers
  logic [NCH-1:0][1:0][OUT_W-1:0]      buf1;
  logic [NCH-1:0][3:0][OUT_W-1:0]      buf2;
  logic [NCH-1:0][NOUT-1:0][OUT_W-1:0] buf3;

  // delay lines, one per stage and channel
  logic [NTAP-1:0][OUT_W-1:0] taps_w [NSTG][NCH];

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [OUT_W-1:0] din;
      logic             sh_en;
      if (s == 0) begin : g_src0
        assign din = {smp[c], {SH{1'b0}}};
      end else if (s == 1) begin : g_src1
        assign din = buf1[c][idx[0]];
      end else begin : g_src2
        assign din = buf2[c][idx];
      end
      assign sh_en = run && (ph == PH_SHIFT) && (stg == 2'(s)) && (ch == 1'(c));
      ipc_tapline #(.W(OUT_W)) u_tl (
        .clk(clk), .rst_n(rst_sync_n), .shift(sh_en), .din(din), .taps(taps_w[s][c])
      );
    end
  end

  // operand selection for the shared ALU
  logic [NTAP-1:0][OUT_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int s = 0; s < NSTG; s++)
      for (int c = 0; c < NCH; c++)
        if (stg == 2'(s) && ch == 1'(c)) sel = taps_w[s][c];
  end

  logic                     inner;
  logic [OUT_W-1:0]         opa, opb, alu_res;
  logic signed [COEF_W-1:0] coef;

  assign inner = (ph == PH_MAC0);
  assign opa   = inner ? sel[1] : sel[0];
  assign opb   = inner ? sel[2] : sel[3];
  assign coef  = coef_rom(stg, !inner);

  ipc_alu #(.W(OUT_W)) u_alu (
    .clk(clk), .rst_n(rst_sync_n), .acc_en(run && inner),
    .opa(opa), .opb(opb), .coef(coef), .res(alu_res)
  );

  // write-back: centre tap to the even slot, midpoint to the odd slot
  logic wr;
  assign wr = run && (ph == PH_MAC1);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buf1 <= '0;
      buf2 <= '0;
      buf3 <= '0;
    end else if (wr) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch == 1'(c)) begin
          if (stg == 2'd0) begin
            buf1[c][0] <= sel[2];
            buf1[c][1] <= alu_res;
          end
          if (stg == 2'd1) begin
            buf2[c][{idx[0], 1'b0}] <= sel[2];
            buf2[c][{idx[0], 1'b1}] <= alu_res;
          end
          if (stg == 2'd2) begin
            buf3[c][{idx, 1'b0}] <= sel[2];
            buf3[c][{idx, 1'b1}] <= alu_res;
          end
        end
      end
    end
  end

  ipc_hold #(.W(OUT_W), .CPO(CPO)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(load),
    .frm_l(buf3[0]), .frm_r(buf3[1]),
    .out_valid(out_valid), .out_l(out_left), .out_r(out_right)
  );

endmodule

// File: rtl/ipc_chain_chk.sv
module ipc_chain_chk #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 23,
  parameter int LAT   = 43
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             load,
  input logic [2*IN_W-1:0] smp,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_left,
  input logic [OUT_W-1:0] out_right
);

  logic       seen_load;
  logic [6:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_load <= 1'b0;
      lat_cnt   <= '0;
    end else begin
      if (load) seen_load <= 1'b1;
      if (accept)                                lat_cnt <= 7'd1;
      else if (lat_cnt != '0 && lat_cnt != '1)   lat_cnt <= lat_cnt + 7'd1;
    end
  end

  assert_quiet_until_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_load |-> (!out_valid && out_left == '0 && out_right == '0));

  assert_frame_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (lat_cnt == 7'(LAT)));

  assert_slot_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load) |=> !out_valid);

  assert_hold_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));

  assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(smp));

endmodule

bind ipc_chain ipc_chain_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .accept(accept), .busy(busy), .load(load),
  .smp(smp), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
);

// File: tb/tb_ipc_chain.sv
`timescale 1ns/1ps
module tb_ipc_chain;

  localparam int CPO  = 4;
  localparam int LAT  = 43;
  localparam int WIN  = 64 * CPO;
  localparam longint MAXV = 4194303;
  localparam longint MINV = -4194304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [19:0] in_left, in_right;
  logic        out_valid;
  logic [22:0] out_left, out_right;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  longint hist [2][3][4];
  longint expf [2][8];
  longint peak;

  always #2.5 clk = ~clk;

  ipc_chain dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic longint clamp(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic stage_push(int c, int s, longint x, output longint ev, output longint od);
    hist[c][s][3] = hist[c][s][2];
    hist[c][s][2] = hist[c][s][1];
    hist[c][s][1] = hist[c][s][0];
    hist[c][s][0] = x;
    ev = hist[c][s][2];
    od = clamp((9 * (hist[c][s][1] + hist[c][s][2]) - (hist[c][s][0] + hist[c][s][3]) + 8) >>> 4);
  endtask

  task automatic model_frame(int c, int x);
    longint a [2];
    longint b [4];
    longint e, o;
    stage_push(c, 0, longint'(x) * 8, a[0], a[1]);
    for (int k = 0; k < 2; k++) begin
      stage_push(c, 1, a[k], e, o);
      b[2*k] = e; b[2*k+1] = o;
    end
    for (int k = 0; k < 4; k++) begin
      stage_push(c, 2, b[k], e, o);
      expf[c][2*k] = e; expf[c][2*k+1] = o;
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 3; s++)
        for (int t = 0; t < 4; t++) hist[c][s][t] = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_model();
  endtask

  // Drive one sample pair; return at the negedge right after the load edge.
  task automatic send(int l, int r, bit chk_lat, bit poke);
    bit bad = 0;
    model_frame(0, l);
    model_frame(1, r);
    in_left = 20'(l); in_right = 20'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i <= LAT; i++) begin
      if (poke && i == 9)  begin in_valid = 1'b1; in_left = 20'h7FFFF; in_right = 20'h80000; end
      if (poke && i == 10) in_valid = 1'b0;
      @(negedge clk);
      if (chk_lat && i < LAT && out_valid !== 1'b0 && !bad) begin
        bad = 1;
        $display("FAIL R2: out_valid=%0b at clock %0d after accept, expected 0", out_valid, i);
      end
    end
    if (chk_lat) begin
      tests++;
      if (out_valid !== 1'b1) begin
        bad = 1;
        $display("FAIL R2: out_valid=%0b at clock %0d after accept, expected 1", out_valid, LAT);
      end
      if (bad) fails++;
    end
  endtask

  // Compare WIN + extra clocks of output against the model frame.
  task automatic check_window(string tag, int extra);
    bit bad = 0;
    tests++;
    for (int k = 0; k < WIN + extra; k++) begin
      int     slot = (k / CPO > 63) ? 63 : k / CPO;
      bit     ev   = (k % CPO) == 0;
      longint gl   = longint'($signed(out_left));
      longint gr   = longint'($signed(out_right));
      if (gl > peak) peak = gl;
      if (gr > peak) peak = gr;
      if (!bad && out_valid !== ev) begin
        bad = 1;
        $display("FAIL %s: out_valid=%0b at clock %0d, expected %0b", tag, out_valid, k, ev);
      end
      if (!bad && gl != expf[0][slot/8]) begin
        bad = 1;
        $display("FAIL %s: left=%0d at clock %0d, expected %0d", tag, gl, k, expf[0][slot/8]);
      end
      if (!bad && gr != expf[1][slot/8]) begin
        bad = 1;
        $display("FAIL %s: right=%0d at clock %0d, expected %0d", tag, gr, k, expf[1][slot/8]);
      end
      @(negedge clk);
    end
    if (bad) fails++;
  endtask

  task automatic check_idle(string tag, int n);
    bit bad = 0;
    tests++;
    for (int k = 0; k < n; k++) begin
      if (!bad && (out_valid !== 1'b0 || out_left !== '0 || out_right !== '0)) begin
        bad = 1;
        $display("FAIL %s: valid=%0b left=%0d right=%0d, expected 0 0 0",
                 tag, out_valid, $signed(out_left), $signed(out_right));
      end
      @(negedge clk);
    end
    if (bad) fails++;
  endtask

  task automatic test_reset_state();
    do_reset();
    check_idle("R1 reset state", 30);
  endtask

  task automatic test_latency();
    do_reset();
    send(1234, -777, 1, 0);                 // R2
    check_window("R2 first frame", 0);
  endtask

  task automatic test_impulse();
    do_reset();
    send(100000, 0, 0, 0);                  // R3 impulse response, R4 chain order
    check_window("R3 impulse head", 0);
    for (int n = 0; n < 4; n++) begin
      send(0, 0, 0, 0);
      check_window("R4 impulse tail", 0);
    end
  endtask

  task automatic test_channels();
    do_reset();
    for (int n = 0; n < 5; n++) begin       // R9 distinct patterns per channel
      send(n * 30000 - 50000, (n % 2 == 0) ? -200000 : 150000, 0, 0);
      check_window("R9 channel split", 0);
    end
  endtask

  task automatic test_saturation();
    int seq_l [8] = '{-524288, 524287, 524287, -524288, 524287, -524288, -524288, 524287};
    do_reset();
    peak = 0;
    for (int n = 0; n < 8; n++) begin
      send(seq_l[n], -seq_l[n] - 1, 0, 0);  // R8 full-scale steps
      check_window("R8 clamp", 0);
    end
    tests++;
    if (peak != MAXV) begin
      fails++;
      $display("FAIL R8: peak output %0d, expected %0d", peak, MAXV);
    end
  endtask

  task automatic test_hold_after_frame();
    do_reset();
    send(300000, -300000, 0, 0);
    check_window("R6 hold past last slot", 48); // R6
    send(-10000, 20000, 0, 0);
    check_window("R5 slot cadence", 0);         // R5
  endtask

  task automatic test_busy_ignored();
    do_reset();
    send(50000, -60000, 0, 1);              // R7 poke during processing
    check_window("R7 poke frame", 0);
    send(70000, 80000, 0, 0);
    check_window("R7 history after poke", 0);
  endtask

  task automatic test_midrun_reset();
    do_reset();
    send(400000, -400000, 0, 0);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    tests++;
    if (out_valid !== 1'b0 || out_left !== '0 || out_right !== '0) begin
      fails++;
      $display("FAIL R10: valid=%0b left=%0d right=%0d right after reset, expected 0 0 0",
               out_valid, $signed(out_left), $signed(out_right));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    check_idle("R10 idle after reset", 10);
    send(5000, 6000, 0, 0);
    check_window("R10 history cleared", 0);
  endtask

  initial begin
    peak = 0;
    test_reset_state();
    test_latency();
    test_impulse();
    test_channels();
    test_saturation();
    test_hold_after_frame();
    test_busy_ignored();
    test_midrun_reset();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule